// File: doc/BRIEF.md
# Endian-Aware Bus Width Matcher

This block sits between a 36-bit memory word and an external data port that can be 36, 18 or 9 bits wide. The word is split into four 9-bit lanes. In the narrow widths a small lane counter picks the half or byte that crosses the port in each access cycle. The counter climbs through the lanes for ascending (little-endian) order and descends for descending (big-endian) order. When the last lane of the word has been moved, the block asks the external word-address counter to advance.

Reads steer the selected lane or lanes of the array word onto the low bits of the port, and the unused upper bits read as zero. Writes copy the low port bits onto every lane position and raise a per-lane write enable only for the lanes being transferred. The array can then merge the word one lane at a time. The three mode pins are sampled during reset and are expected to stay fixed while the block runs.

Top module: `bus_width_matcher`

## Requirements
- R1: `bus_match`=0 selects the 36-bit width whatever `size_byte` is. `bus_match`=1 with `size_byte`=0 selects the 18-bit width. `bus_match`=1 with `size_byte`=1 selects the 9-bit width.
- R2: In 36-bit width, `port_rdata` equals `arr_rdata` in the same cycle. A write beat raises all four lane enables. Every beat with `inc_mode`=1 pulses `word_adv`.
- R3: In 18-bit ascending order, the first beat carries `arr_rdata[17:0]` on `port_rdata[17:0]` and the second carries `arr_rdata[35:18]`. `port_rdata[35:18]` reads zero.
- R4: In 9-bit ascending order, successive beats carry lanes 0, 1, 2, 3, where lane n is `arr_rdata[9n+8:9n]`. The lane appears on `port_rdata[8:0]`, and all higher port bits read zero.
- R5: With `big_endian`=1 the order reverses. The 18-bit width sends the high half first, and the 9-bit width sends lanes 3, 2, 1, 0.
- R6: `word_adv` is high exactly in a beat (`xfer_en`=1, `inc_mode`=1) that moves the final lane of the word. The next beat starts again at the first lane.
- R7: A beat with `inc_mode`=0 leaves the lane counter unchanged. The next beat moves the same lane again, and `word_adv` stays low.
- R8: When `xfer_en`=1 and `wr_en`=1, `arr_lane_we` bit n is set for each lane n being moved: one bit in 9-bit width, bits {1,0} or {3,2} in 18-bit width. Each such lane of `arr_wdata` carries the matching low port bits (`port_wdata[8:0]` for bytes, `port_wdata[17:0]` for halves). Otherwise `arr_lane_we` is 0.
- R9: `big_endian` has no effect in 36-bit width.
- R10: Synchronous active-low reset places the lane counter on the first lane of the selected order. A cycle with `xfer_en`=0 moves nothing: `arr_lane_we`=0, `word_adv`=0 and the lane counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_match | input | 1 | 1 enables a narrow port width |
| size_byte | input | 1 | With `bus_match`=1: 1 selects 9-bit, 0 selects 18-bit |
| big_endian | input | 1 | 1 selects descending lane order |
| xfer_en | input | 1 | Access strobe: one lane transfer this cycle |
| wr_en | input | 1 | Transfer is a write |
| inc_mode | input | 1 | Word address counter is in increment mode |
| arr_rdata | input | 36 | Word read from the array |
| port_wdata | input | 36 | Write data from the narrow port (low bits used) |
| port_rdata | output | 36 | Read data to the narrow port |
| arr_wdata | output | 36 | Write data steered onto the array lanes |
| arr_lane_we | output | 4 | Per-lane array write enable |
| word_adv | output | 1 | Advance the word address |

## Verification
The assertions take the three mode pins as constant whenever reset is released. The lane-range and ordering properties would not hold if the width changed in the middle of a word. The stimulus therefore changes the mode pins only while `rst_n` is low and holds reset for several cycles after each change. It also drives every input from a fixed time after the rising edge, so the combinational outputs are settled before they are sampled.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  localparam int LANES = 4;
  localparam int SUB_W = 2;

  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_HALF = 2'd1,
    MODE_BYTE = 2'd2
  } width_mode_e;

  typedef logic [SUB_W-1:0] lane_t;

  // lane where a word starts
  function automatic lane_t first_lane(width_mode_e m, logic desc);
    if (m == MODE_FULL || !desc) return lane_t'(0);
    if (m == MODE_HALF) return lane_t'(1);
    return lane_t'(LANES - 1);
  endfunction

  // lane that completes a word
  function automatic lane_t final_lane(width_mode_e m, logic desc);
    if (m == MODE_FULL || desc) return lane_t'(0);
    if (m == MODE_HALF) return lane_t'(1);
    return lane_t'(LANES - 1);
  endfunction

  // next lane, wrapping to the start after the last one
  function automatic lane_t step_lane(lane_t cur, width_mode_e m, logic desc);
    if (cur == final_lane(m, desc)) return first_lane(m, desc);
    if (desc) return lane_t'(cur - lane_t'(1));
    return lane_t'(cur + lane_t'(1));
  endfunction

  // lanes of the array word touched by the current position
  function automatic logic [LANES-1:0] lane_mask(lane_t cur, width_mode_e m);
    logic [LANES-1:0] mk;
    mk = '0;
    for (int i = 0; i < LANES; i++) begin
      case (m)
        MODE_FULL: mk[i] = 1'b1;
        MODE_HALF: mk[i] = ((i / (LANES / 2)) == int'(cur[0]));
        default:   mk[i] = (i == int'(cur));
      endcase
    end
    return mk;
  endfunction

endpackage

// File: rtl/bwm_mode_decode.sv
module bwm_mode_decode
  import bwm_pkg::*;
(
  input  logic        bus_match,
  input  logic        size_byte,
  input  logic        big_endian,
  output width_mode_e mode,
  output logic        desc
);

  always_comb begin
    if (!bus_match)     mode = MODE_FULL;
    else if (size_byte) mode = MODE_BYTE;
    else                mode = MODE_HALF;
  end

  // order only matters when the word is split
  assign desc = big_endian & bus_match;

endmodule

// File: rtl/bwm_lane_seq.sv
module bwm_lane_seq
  import bwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  width_mode_e mode,
  input  logic        desc,
  input  logic        xfer_en,
  input  logic        inc_mode,
  output lane_t       cur_lane,
  output logic        word_adv
);

  lane_t cur_q;
  logic  step_now;
  logic  at_final;

  assign step_now = xfer_en & inc_mode;
  assign at_final = (cur_q == final_lane(mode, desc));
  assign word_adv = step_now & at_final;
  assign cur_lane = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        cur_q <= first_lane(mode, desc);
    else if (step_now) cur_q <= step_lane(cur_q, mode, desc);
  end

  p_hold_no_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && !inc_mode) |=> $stable(cur_q));

  p_wrap_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_adv |=> (cur_q == first_lane(mode, desc)));

  p_full_every_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FULL && xfer_en && inc_mode) |-> word_adv);

  p_half_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HALF) |-> (cur_q[1] == 1'b0));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> $stable(cur_q));

endmodule

// File: rtl/bwm_lane_mux.sv
module bwm_lane_mux
  import bwm_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  width_mode_e              mode,
  input  lane_t                    cur_lane,
  input  logic                     xfer_en,
  input  logic                     wr_en,
  input  logic [LANE_W*LANES-1:0]  arr_rdata,
  input  logic [LANE_W*LANES-1:0]  port_wdata,
  output logic [LANE_W*LANES-1:0]  port_rdata,
  output logic [LANE_W*LANES-1:0]  arr_wdata,
  output logic [LANES-1:0]         arr_lane_we
);

  localparam int WORD_W = LANE_W * LANES;
  localparam int HALF_W = WORD_W / 2;

  logic [LANES-1:0] sel_mask;
  logic             wr_beat;

  assign sel_mask    = lane_mask(cur_lane, mode);
  assign wr_beat     = xfer_en & wr_en;
  assign arr_lane_we = wr_beat ? sel_mask : '0;

  // write steering: each lane takes its own slice, its half slice, or the byte
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] wd_lane;
    always_comb begin
      case (mode)
        MODE_FULL: wd_lane = port_wdata[g*LANE_W +: LANE_W];
        MODE_HALF: wd_lane = port_wdata[(g % (LANES/2))*LANE_W +: LANE_W];
        default:   wd_lane = port_wdata[LANE_W-1:0];
      endcase
    end
    assign arr_wdata[g*LANE_W +: LANE_W] = wd_lane;
  end

  // read steering onto the low port bits
  always_comb begin
    port_rdata = '0;
    case (mode)
      MODE_FULL: port_rdata = arr_rdata;
      MODE_HALF: port_rdata[HALF_W-1:0] = arr_rdata[int'(cur_lane[0])*HALF_W +: HALF_W];
      default:   port_rdata[LANE_W-1:0] = arr_rdata[int'(cur_lane)*LANE_W +: LANE_W];
    endcase
  end

  p_byte_we_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BYTE) |-> $onehot0(arr_lane_we));

  p_half_we_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HALF && arr_lane_we != '0) |-> ($countones(arr_lane_we) == 2));

  p_full_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FULL) |-> (port_rdata == arr_rdata));

  p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BYTE) |-> (port_rdata[WORD_W-1:LANE_W] == '0));

  p_half_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HALF) |-> (port_rdata[WORD_W-1:HALF_W] == '0));

endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher
  import bwm_pkg::*;
#(
  parameter int LANE_W = 9,
  localparam int WORD_W = LANE_W * 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_match,
  input  logic              size_byte,
  input  logic              big_endian,
  input  logic              xfer_en,
  input  logic              wr_en,
  input  logic              inc_mode,
  input  logic [WORD_W-1:0] arr_rdata,
  input  logic [WORD_W-1:0] port_wdata,
  output logic [WORD_W-1:0] port_rdata,
  output logic [WORD_W-1:0] arr_wdata,
  output logic [3:0]        arr_lane_we,
  output logic              word_adv
);

  width_mode_e mode;
  logic        desc;
  lane_t       cur_lane;

  bwm_mode_decode u_dec (
    .bus_match  (bus_match),
    .size_byte  (size_byte),
    .big_endian (big_endian),
    .mode       (mode),
    .desc       (desc)
  );

  bwm_lane_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .desc     (desc),
    .xfer_en  (xfer_en),
    .inc_mode (inc_mode),
    .cur_lane (cur_lane),
    .word_adv (word_adv)
  );

  bwm_lane_mux #(.LANE_W(LANE_W)) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .cur_lane    (cur_lane),
    .xfer_en     (xfer_en),
    .wr_en       (wr_en),
    .arr_rdata   (arr_rdata),
    .port_wdata  (port_wdata),
    .port_rdata  (port_rdata),
    .arr_wdata   (arr_wdata),
    .arr_lane_we (arr_lane_we)
  );

  p_order_ignored_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_match) |-> (cur_lane == '0));

  p_mode_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_match && size_byte) |-> (mode == MODE_BYTE));

  p_no_write_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en) |-> (arr_lane_we == 4'b0000 && !word_adv));

endmodule

// File: tb/bus_width_matcher_bench.sv
module bus_width_matcher_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_match = 1'b0, size_byte = 1'b0, big_endian = 1'b0;
  logic        xfer_en = 1'b0, wr_en = 1'b0, inc_mode = 1'b0;
  logic [35:0] arr_rdata = '0, port_wdata = '0;
  logic [35:0] port_rdata, arr_wdata;
  logic [3:0]  arr_lane_we;
  logic        word_adv;

  always #5 clk = ~clk;

  bus_width_matcher u_bus_width_matcher (
    .clk(clk), .rst_n(rst_n), .bus_match(bus_match), .size_byte(size_byte),
    .big_endian(big_endian), .xfer_en(xfer_en), .wr_en(wr_en), .inc_mode(inc_mode),
    .arr_rdata(arr_rdata), .port_wdata(port_wdata), .port_rdata(port_rdata),
    .arr_wdata(arr_wdata), .arr_lane_we(arr_lane_we), .word_adv(word_adv)
  );

  typedef struct {
    logic [35:0] rd;
    logic [3:0]  we;
    logic [35:0] wd;
    logic        adv;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // bench model state
  int m_width;   // 0: 36-bit, 1: 18-bit, 2: 9-bit
  bit m_desc;
  int m_step;

  function automatic logic [35:0] lane_bits(logic [3:0] we);
    logic [35:0] m;
    m = '0;
    for (int i = 0; i < 4; i++) if (we[i]) m[i*9 +: 9] = 9'h1FF;
    return m;
  endfunction

  function automatic int beats_per_word(int w);
    return (w == 0) ? 1 : (w == 1) ? 2 : 4;
  endfunction

  // position within the word -> lane (9-bit) or half (18-bit)
  function automatic int pos_of(int w, bit d, int k);
    if (w == 0) return 0;
    if (w == 1) return d ? 1 - k : k;
    return d ? 3 - k : k;
  endfunction

  task automatic set_mode(input bit bm, input bit sz, input bit be);
    @(posedge clk); #1;
    rst_n = 1'b0; xfer_en = 0; wr_en = 0; inc_mode = 0;
    bus_match = bm; size_byte = sz; big_endian = be;
    m_width = !bm ? 0 : (sz ? 2 : 1);
    m_desc  = bm && be;
    m_step  = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic beat(input bit x, input bit w, input bit inc,
                      input logic [35:0] rd, input logic [35:0] wd, input string tag);
    exp_t e;
    int   p;
    @(posedge clk); #1;
    xfer_en = x; wr_en = w; inc_mode = inc; arr_rdata = rd; port_wdata = wd;
    p = pos_of(m_width, m_desc, m_step);
    e.tag = tag;
    case (m_width)
      0: begin e.rd = rd; e.we = 4'hF; e.wd = wd; end
      1: begin e.rd = {18'b0, rd[p*18 +: 18]}; e.we = p ? 4'hC : 4'h3; e.wd = {2{wd[17:0]}}; end
      default: begin e.rd = {27'b0, rd[p*9 +: 9]}; e.we = 4'(1 << p); e.wd = {4{wd[8:0]}}; end
    endcase
    if (!(x && w)) e.we = 4'h0;
    e.adv = x && inc && (m_step == beats_per_word(m_width) - 1);
    sb.push_back(e);
    if (x && inc) m_step = (m_step + 1) % beats_per_word(m_width);
  endtask

  task automatic rd_beats(input int n, input bit inc, input string tag);
    for (int i = 0; i < n; i++) beat(1, 0, inc, {$urandom, $urandom}, {$urandom, $urandom}, tag);
  endtask

  task automatic wr_beats(input int n, input string tag);
    for (int i = 0; i < n; i++) beat(1, 1, 1, {$urandom, $urandom}, {$urandom, $urandom}, tag);
  endtask

  // monitor: compares at the falling edge, once the driven inputs have settled
  initial begin
    exp_t e;
    logic [35:0] mk;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        e  = sb.pop_front();
        mk = lane_bits(e.we);
        checks++;
        if (port_rdata !== e.rd || arr_lane_we !== e.we || word_adv !== e.adv ||
            (arr_wdata & mk) !== (e.wd & mk)) begin
          errors++;
          $display("FAIL %s: rd=%h exp %h we=%b exp %b adv=%b exp %b wd=%h exp %h",
                   e.tag, port_rdata, e.rd, arr_lane_we, e.we, word_adv, e.adv,
                   arr_wdata & mk, e.wd & mk);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 R2 R10: 36-bit width, reset state then reads and writes
    set_mode(0, 0, 0);
    beat(0, 0, 1, 36'h123456789, '0, "R10 idle after reset");
    beat(0, 1, 1, 36'hABCDEF012, 36'h5A5A5A5A5, "R10 no strobe no write");
    rd_beats(3, 1, "R2 full read");
    wr_beats(3, "R2 full write");
    // R9: order pin ignored in full width
    set_mode(0, 0, 1);
    rd_beats(2, 1, "R9 full desc read");
    wr_beats(2, "R9 full desc write");
    set_mode(0, 1, 1);
    rd_beats(2, 1, "R1 full with size set");
    // R3: 18-bit ascending
    set_mode(1, 0, 0);
    beat(0, 0, 0, 36'hFEDCBA987, '0, "R10 half first lane");
    rd_beats(4, 1, "R3 half asc read");
    wr_beats(4, "R8 half asc write");
    // R4: 9-bit ascending, with holds
    set_mode(1, 1, 0);
    beat(0, 0, 0, 36'h13579BDF0, '0, "R10 byte first lane");
    rd_beats(8, 1, "R4 byte asc read");
    rd_beats(1, 1, "R4 byte asc read");
    rd_beats(3, 0, "R7 hold no inc");
    beat(0, 0, 1, 36'h2468ACE13, '0, "R10 idle holds lane");
    rd_beats(3, 1, "R6 complete word");
    wr_beats(8, "R8 byte asc write");
    // R5: descending orders
    set_mode(1, 1, 1);
    rd_beats(8, 1, "R5 byte desc read");
    wr_beats(4, "R8 byte desc write");
    rd_beats(2, 0, "R7 desc hold");
    rd_beats(4, 1, "R6 desc word");
    set_mode(1, 0, 1);
    rd_beats(4, 1, "R5 half desc read");
    wr_beats(4, "R8 half desc write");
    beat(1, 1, 0, 36'h0F0F0F0F0, 36'h3C3C3C3C3, "R7 half hold write");
    rd_beats(2, 1, "R6 half desc word");
    @(posedge clk); #1 xfer_en = 0; wr_en = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule